// File: doc/BRIEF.md
# Serial-Programmed Feedback Divider Control

This block is the digital control path of a clock synthesizer that can deliberately run its output a few percent off nominal. A slow three-wire serial port (serial clock, serial data, load strobe) delivers a 6-bit divider value, most-significant bit first. The value is collected in a shift register while the load strobe is high and is committed to a control register when the strobe drops. All three serial wires are brought into the core clock domain through two-flop synchronizers, and edges are detected there.

A margin-enable input chooses the effective feedback divisor: with it low the divisor is the fixed nominal value 50 (a 12 MHz reference times 50 puts the oscillator at 600 MHz, divided by 6 for a 100 MHz output); with it high the programmed value is used. Each divisor step of one count moves the output by 2 %. The block reports the effective divisor, a signed margin percentage and a flag for divisors that would place the oscillator outside its 540 to 680 MHz range. A divide-by-M counter on the core clock produces one feedback pulse per M core cycles and only adopts a new divisor at its terminal count.

Top module: `fbdiv_margin_ctrl`

## Requirements
- R1: After reset the control register holds 50; with margin enable low the effective divisor is 50, the margin output is 0, the lock-range flag is low and the feedback pulse period is 50 core cycles.
- R2: While the load strobe is high, each rising edge of the serial clock shifts in the serial data bit; the first bit sent ends up in bit 5 and the sixth in bit 0.
- R3: A high-to-low transition of the load strobe copies the shift register into the control register, visible on the effective divisor (margin enabled) within 4 core cycles of the strobe falling.
- R4: While the load strobe is low, serial clock and data activity changes neither the control register nor the shift register (a later load with no clock edges re-commits the previously loaded value).
- R5: A serial load performed with margin enable low is accepted, while the effective divisor stays 50 until margin enable rises.
- R6: With margin enable high the effective divisor equals the control register; lowering margin enable restores 50 by the following core cycle, and raising it again restores the programmed value.
- R7: The margin output is the 8-bit two's-complement value (M − 50) × 2, in percent: 45 gives −10 (0xF6), 55 gives +10.
- R8: The lock-range flag is high exactly when 12 × M is below 540 or above 680, that is for M ≤ 44 or M ≥ 57; 45 and 56 are in range.
- R9: The feedback output is a one-cycle pulse repeating every M core cycles, M being the divisor in force.
- R10: A divisor change takes effect only at the counter's terminal count: the period in progress completes with the old divisor, the next one uses the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous to the core clock) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_i | input | 1 | Load strobe: high enables shifting, falling edge commits |
| margin_en_i | input | 1 | 0 = nominal divisor, 1 = programmed divisor |
| div_eff_o | output | 6 | Effective feedback divisor |
| margin_pct_o | output | 8 | Signed output offset in percent |
| no_lock_o | output | 1 | Divisor outside the oscillator range |
| fb_pulse_o | output | 1 | Feedback pulse, one per M core cycles |

## Verification
A serial load reaches the control register three core edges after the strobe falls (two synchronizer stages plus the commit register), so the bench lets six core cycles pass after the strobe before queuing a status comparison. Divisor, margin and lock outputs are combinational on the control register and margin enable, so status items are compared one full core cycle after the stimulus, at a falling clock edge. Feedback periods are measured between pulses; since a new divisor waits for the terminal count, the monitor discards the period in progress and the one after and compares the third, while the dedicated R10 item compares the period that was interrupted by the change against the old divisor.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  // Divider value width and nominal setting
  parameter int DIV_W       = 6;
  parameter int NOM_DIV     = 50;
  // Reference and oscillator window, MHz
  parameter int REF_MHZ     = 12;
  parameter int VCO_MIN_MHZ = 540;
  parameter int VCO_MAX_MHZ = 680;
  // Percent per divider count and width of the margin output
  parameter int STEP_PCT    = 2;
  parameter int PCT_W       = 8;
  // Synchronizer depth
  parameter int SYNC_STAGES = 2;
endpackage

// File: rtl/fbdiv_sync.sv
module fbdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = async_i;
    end else begin : g_rest
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fbdiv_serial_port.sv
module fbdiv_serial_port
  import fbdiv_pkg::*;
#(
  parameter int W   = DIV_W,
  parameter int NOM = NOM_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_s_i,
  input  logic         sdat_s_i,
  input  logic         sld_s_i,
  output logic [W-1:0] ctl_o
);
  localparam logic [W-1:0] RST_VAL = W'(NOM);

  logic         sclk_d_q, sclk_d_d;
  logic         sld_d_q,  sld_d_d;
  logic [W-1:0] shreg_q,  shreg_d;
  logic [W-1:0] ctl_q,    ctl_d;
  logic         sclk_rise, shift_en, ld_fall;

  always_comb begin
    sclk_rise = sclk_s_i & ~sclk_d_q;
    shift_en  = sclk_rise & sld_s_i;
    ld_fall   = ~sld_s_i & sld_d_q;

    sclk_d_d  = sclk_s_i;
    sld_d_d   = sld_s_i;

    shreg_d = shreg_q;
    if (shift_en) shreg_d = {shreg_q[W-2:0], sdat_s_i};

    ctl_d = ctl_q;
    if (ld_fall) ctl_d = shreg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sld_d_q  <= 1'b0;
      shreg_q  <= RST_VAL;
      ctl_q    <= RST_VAL;
    end else begin
      sclk_d_q <= sclk_d_d;
      sld_d_q  <= sld_d_d;
      if (shift_en) shreg_q <= shreg_d;
      if (ld_fall)  ctl_q   <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;

  AST_CTL_ONLY_ON_LDFALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_fall |=> $stable(ctl_q)); // R3

  AST_SHREG_IDLE_UNLOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sld_s_i |=> $stable(shreg_q)); // R4
endmodule

// File: rtl/fbdiv_select.sv
module fbdiv_select
  import fbdiv_pkg::*;
#(
  parameter int W     = DIV_W,
  parameter int NOM   = NOM_DIV,
  parameter int REF   = REF_MHZ,
  parameter int VMIN  = VCO_MIN_MHZ,
  parameter int VMAX  = VCO_MAX_MHZ,
  parameter int STEP  = STEP_PCT,
  parameter int PW    = PCT_W
) (
  input  logic          margin_en_i,
  input  logic [W-1:0]  ctl_i,
  output logic [W-1:0]  div_eff_o,
  output logic [W-1:0]  div_cnt_o,
  output logic [PW-1:0] pct_o,
  output logic          no_lock_o
);
  localparam logic [W-1:0] NOM_V = W'(NOM);

  int vco_mhz;
  int delta;

  always_comb begin
    div_eff_o = margin_en_i ? ctl_i : NOM_V;
    // a zero divisor would stall the counter; run it as divide-by-one
    div_cnt_o = (div_eff_o == '0) ? W'(1) : div_eff_o;
    vco_mhz   = int'(div_eff_o) * REF;
    no_lock_o = (vco_mhz < VMIN) || (vco_mhz > VMAX);
    delta     = int'(div_eff_o) - NOM;
    pct_o     = PW'(delta * STEP);
  end
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
  import fbdiv_pkg::*;
#(
  parameter int W   = DIV_W,
  parameter int NOM = NOM_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] RST_DIV = W'(NOM);
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] m_cur_q, m_cur_d;
  logic         pulse_q, pulse_d;
  logic         at_term;

  always_comb begin
    at_term = (cnt_q == (m_cur_q - ONE));
    cnt_d   = at_term ? '0 : cnt_q + ONE;
    m_cur_d = at_term ? div_i : m_cur_q;
    pulse_d = at_term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      m_cur_q <= RST_DIV;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      if (at_term) m_cur_q <= m_cur_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < m_cur_q); // R9

  AST_DIV_HELD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != (m_cur_q - ONE)) |=> $stable(m_cur_q)); // R10
endmodule

// File: rtl/fbdiv_margin_ctrl.sv
module fbdiv_margin_ctrl
  import fbdiv_pkg::*;
#(
  parameter int W      = DIV_W,
  parameter int NOM    = NOM_DIV,
  parameter int REF    = REF_MHZ,
  parameter int VMIN   = VCO_MIN_MHZ,
  parameter int VMAX   = VCO_MAX_MHZ,
  parameter int STEP   = STEP_PCT,
  parameter int PW     = PCT_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ser_clk_i,
  input  logic          ser_dat_i,
  input  logic          ser_ld_i,
  input  logic          margin_en_i,
  output logic [W-1:0]  div_eff_o,
  output logic [PW-1:0] margin_pct_o,
  output logic          no_lock_o,
  output logic          fb_pulse_o
);
  // lockable divisor window and the margin it spans
  localparam int LOCK_LO = (VMIN + REF - 1) / REF;
  localparam int LOCK_HI = VMAX / REF;
  localparam int PCT_LO  = (LOCK_LO - NOM) * STEP;
  localparam int PCT_HI  = (LOCK_HI - NOM) * STEP;

  logic [1:0]   rst_q;
  logic         rst_n_s;
  logic [2:0]   ser_s;
  logic [W-1:0] ctl;
  logic [W-1:0] div_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  fbdiv_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .async_i ({ser_ld_i, ser_dat_i, ser_clk_i}),
    .sync_o  (ser_s)
  );

  fbdiv_serial_port #(.W(W), .NOM(NOM)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .sclk_s_i (ser_s[0]),
    .sdat_s_i (ser_s[1]),
    .sld_s_i  (ser_s[2]),
    .ctl_o    (ctl)
  );

  fbdiv_select #(
    .W(W), .NOM(NOM), .REF(REF), .VMIN(VMIN), .VMAX(VMAX), .STEP(STEP), .PW(PW)
  ) u_sel (
    .margin_en_i (margin_en_i),
    .ctl_i       (ctl),
    .div_eff_o   (div_eff_o),
    .div_cnt_o   (div_cnt),
    .pct_o       (margin_pct_o),
    .no_lock_o   (no_lock_o)
  );

  fbdiv_counter #(.W(W), .NOM(NOM)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .div_i   (div_cnt),
    .pulse_o (fb_pulse_o)
  );

  AST_NOMINAL_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !margin_en_i |-> (int'(div_eff_o) == NOM) && (margin_pct_o == '0) && !no_lock_o); // R5

  AST_LOCKED_PCT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !no_lock_o |-> (int'($signed(margin_pct_o)) >= PCT_LO) &&
                   (int'($signed(margin_pct_o)) <= PCT_HI)); // R8
endmodule

// File: tb/fbdiv_margin_ctrl_tb_top.sv
`timescale 1ns/1ps
module fbdiv_margin_ctrl_tb_top;
  localparam int HALF_SER = 4;
  localparam int WDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk, sdat, sld, men;
  logic [5:0] div_eff;
  logic [7:0] pct;
  logic       no_lock, fb;

  always #2 clk = ~clk;

  fbdiv_margin_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ser_clk_i    (sclk),
    .ser_dat_i    (sdat),
    .ser_ld_i     (sld),
    .margin_en_i  (men),
    .div_eff_o    (div_eff),
    .margin_pct_o (pct),
    .no_lock_o    (no_lock),
    .fb_pulse_o   (fb)
  );

  typedef enum int {K_STAT, K_PER, K_NEXT} kind_e;
  typedef struct {
    kind_e kind;
    int    e_div;
    int    e_pct;
    int    e_nl;
    int    e_iv;
    string tag;
  } item_t;

  item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // pulse interval tracker
  int since   = 0;
  int last_iv = 0;
  int pulse_n = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      since = 0;
    end else if (fb) begin
      last_iv = since + 1;
      since   = 0;
      pulse_n = pulse_n + 1;
    end else begin
      since = since + 1;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares as results appear
  initial begin
    forever begin
      item_t it;
      int    start;
      wait (exp_q.size() != 0);
      it = exp_q[0];
      case (it.kind)
        K_STAT: begin
          @(negedge clk);
          cmp(it.tag, "divisor", int'(div_eff), it.e_div);
          cmp(it.tag, "margin",  int'($signed(pct)), it.e_pct);
          cmp(it.tag, "no_lock", int'(no_lock), it.e_nl);
        end
        K_PER: begin
          start = pulse_n;
          wait (pulse_n == start + 3);
          cmp(it.tag, "period", last_iv, it.e_iv);
        end
        default: begin
          start = pulse_n;
          wait (pulse_n == start + 1);
          cmp(it.tag, "period", last_iv, it.e_iv);
        end
      endcase
      void'(exp_q.pop_front());
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input item_t it);
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic exp_stat(input int d, input int p, input int nl, input string tag);
    item_t it;
    it.kind = K_STAT; it.e_div = d; it.e_pct = p; it.e_nl = nl; it.e_iv = 0; it.tag = tag;
    push(it);
  endtask

  task automatic exp_per(input kind_e k, input int iv, input string tag);
    item_t it;
    it.kind = k; it.e_div = 0; it.e_pct = 0; it.e_nl = 0; it.e_iv = iv; it.tag = tag;
    push(it);
  endtask

  task automatic ser_write(input logic [5:0] v);
    sld = 1'b1;
    cyc(HALF_SER);
    for (int b = 5; b >= 0; b--) begin
      sdat = v[b];
      cyc(HALF_SER);
      sclk = 1'b1;
      cyc(HALF_SER);
      sclk = 1'b0;
    end
    cyc(HALF_SER);
    sld = 1'b0;
    cyc(6);
  endtask

  initial begin
    cyc(WDOG_CYC);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL all watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; sld = 1'b0; men = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    // R1: reset state
    exp_stat(50, 0, 0, "R1");
    exp_per(K_PER, 50, "R1");

    // R5: load with margin off is kept but not applied
    ser_write(6'd45);
    exp_stat(50, 0, 0, "R5");
    men = 1'b1;
    exp_stat(45, -10, 0, "R5");
    // R3, R7: committed value and its margin
    exp_per(K_PER, 45, "R9");

    ser_write(6'd55);
    exp_stat(55, 10, 0, "R7");

    // R2: asymmetric pattern 100110 (38); reversed order would read 25
    ser_write(6'b100110);
    exp_stat(38, -24, 1, "R2");

    // R8: lock window edges
    ser_write(6'd44);
    exp_stat(44, -12, 1, "R8");
    ser_write(6'd56);
    exp_stat(56, 12, 0, "R8");
    ser_write(6'd57);
    exp_stat(57, 14, 1, "R8");
    exp_per(K_PER, 57, "R9");

    // R4: serial activity with load low is ignored
    for (int k = 0; k < 6; k++) begin
      sdat = k[0];
      cyc(HALF_SER);
      sclk = 1'b1;
      cyc(HALF_SER);
      sclk = 1'b0;
    end
    cyc(6);
    exp_stat(57, 14, 1, "R4");
    sld = 1'b1;
    cyc(8);
    sld = 1'b0;
    cyc(6);
    exp_stat(57, 14, 1, "R4");

    // R6: mode toggling
    men = 1'b0;
    exp_stat(50, 0, 0, "R6");
    men = 1'b1;
    exp_stat(57, 14, 1, "R6");

    // R10: change in mid-period keeps the running period
    men = 1'b0;
    ser_write(6'd45);
    exp_per(K_PER, 50, "R10");
    do @(negedge clk); while (!fb);
    cyc(10);
    men = 1'b1;
    exp_per(K_NEXT, 50, "R10");
    exp_per(K_PER, 45, "R10");

    cyc(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule